// File: doc/BRIEF.md
# Audio Sample DMA Engine

This block moves 32-bit stereo sample frames (two signed 16-bit channels at 48 kHz, so four bytes per frame) between system memory and a codec's sample streams. It has two channels. The playback channel reads words from memory and offers them on an outgoing valid/ready stream. The capture channel takes words from an incoming valid/ready stream and writes them to memory. Each channel has three registers on a shared 32-bit register bus: an enable bit, a byte address and a count of bytes left. The address and count registers are live counters, so the processor can read back how far a transfer has progressed.

Both channels share one request/acknowledge memory port. A small arbiter state machine owns that port and has three states. `ARB_IDLE` waits for work. It moves to `ARB_FETCH` when the playback channel wants a word, or else to `ARB_STORE` when the capture channel holds a word to write. `ARB_FETCH` and `ARB_STORE` each hold a single-word request until `mem_ack`, then return to `ARB_IDLE`. Each completed handshake advances the serving channel's address and reduces its count by the bytes moved. When an enabled channel's count reaches zero through such a handshake, the block raises a one-cycle interrupt for that channel.

Top module: `audio_dma`

## Requirements
- R1: After reset, every channel register reads 0, both interrupts are low, `mem_req` is low, `play_valid` is low and `cap_ready` is low.
- R2: Register indices on `reg_idx` are as follows. Playback: 4 = control, 5 = address, 6 = count. Capture: 8 = control, 9 = address, 10 = count. Only bit 0 of a control register is stored, and it reads back in bit 0. Any other index reads 0, and writes to it have no effect.
- R3: A channel whose enable bit is 0 starts no memory request. The capture channel keeps `cap_ready` low while it is disabled.
- R4: The playback channel reads the word at its address (`mem_we` = 0) and presents it on `play_data` with `play_valid` until `play_ready` accepts it. Frames leave in address order.
- R5: Each completed handshake moves min(count, 4) bytes. The address register grows by that amount and the count register shrinks by the same amount.
- R6: An interrupt (`irq_play` or `irq_cap`) is high for exactly one cycle, in the cycle after the handshake that brought an enabled channel's count to zero. It pulses once per drained count.
- R7: The capture channel raises `cap_ready` only when it is enabled, its count is nonzero and its one-word buffer is empty. It writes each accepted word to its address with `mem_we` = 1.
- R8: A channel that is enabled with a count of zero starts no request and raises no interrupt.
- R9: In `ARB_IDLE`, when both channels want the port in the same cycle, the playback fetch is issued first.
- R10: If the processor writes a count register in the same cycle as that channel's handshake completes, the written value wins and no interrupt is raised. The address register still advances.
- R11: While `mem_req` is high and no acknowledge has arrived, `mem_addr`, `mem_we` and (for writes) `mem_wdata` hold steady. This holds even if the processor rewrites the address register. The completing handshake then advances whatever value the address register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_idx`) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write (capture), 0 = read (playback) |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| play_valid | output | 1 | Playback frame valid |
| play_ready | input | 1 | Playback sink ready |
| play_data | output | 32 | Playback frame |
| cap_valid | input | 1 | Capture frame valid |
| cap_ready | output | 1 | Capture buffer can accept a frame |
| cap_data | input | 32 | Capture frame |
| irq_play | output | 1 | Playback count drained pulse |
| irq_cap | output | 1 | Capture count drained pulse |

## Verification
Two pairs of events can coincide in one cycle. The first pair is a memory acknowledge and a processor write to the same channel's count. The bench holds the acknowledge back, then releases it in the very cycle that carries the count write. It then reads back the written count, the advanced address and the absence of an interrupt. The second pair is both channels asking for the port while the arbiter is idle. The bench stalls a playback fetch, loads a capture frame behind it, then acknowledges the fetch. After that it checks that the next request is the playback read at the next address and that the capture store follows it.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_FETCH = 2'd1,
        ARB_STORE = 2'd2
    } arb_state_e;

    localparam int NUM_CH      = 2;
    localparam int CH_PLAY     = 0;
    localparam int CH_CAP      = 1;

    // register bank layout: channel c occupies BANK_FIRST + c*BANK_STRIDE + field
    localparam int BANK_FIRST  = 4;
    localparam int BANK_STRIDE = 4;
    localparam int FLD_CTRL    = 0;
    localparam int FLD_ADDR    = 1;
    localparam int FLD_LEFT    = 2;

endpackage

// File: rtl/audio_dma_chan.sv
module audio_dma_chan #(
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_addr,
    input  logic          wr_left,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    output logic          en,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] left,
    output logic          irq
);
    localparam logic [DW-1:0] WB = DW'(WORD_BYTES);

    logic [DW-1:0] moved;

    always_comb begin
        moved = (left < WB) ? left : WB;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            addr <= '0;
            left <= '0;
            irq  <= 1'b0;
        end else begin
            if (wr_ctrl) en <= wdata[0];

            if (wr_addr)   addr <= wdata;
            else if (step) addr <= addr + moved;

            if (wr_left)   left <= wdata;
            else if (step) left <= left - moved;

            irq <= step && en && !wr_left && (moved != '0) && (left == moved);
        end
    end
endmodule

// File: rtl/audio_dma_arb.sv
module audio_dma_arb
    import audio_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       play_want,
    input  logic       cap_want,
    input  logic       mem_ack,
    output arb_state_e state,
    output logic       mem_req,
    output logic       mem_we,
    output logic       launch_play,
    output logic       launch_cap,
    output logic       play_step,
    output logic       cap_step
);
    arb_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ARB_IDLE: begin
                if (play_want)     nxt = ARB_FETCH;
                else if (cap_want) nxt = ARB_STORE;
            end
            ARB_FETCH: if (mem_ack) nxt = ARB_IDLE;
            ARB_STORE: if (mem_ack) nxt = ARB_IDLE;
            default:   nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        mem_req     = (state != ARB_IDLE);
        mem_we      = (state == ARB_STORE);
        launch_play = (state == ARB_IDLE) && play_want;
        launch_cap  = (state == ARB_IDLE) && !play_want && cap_want;
        play_step   = (state == ARB_FETCH) && mem_ack;
        cap_step    = (state == ARB_STORE) && mem_ack;
    end
endmodule

// File: rtl/audio_dma.sv
module audio_dma
    import audio_dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [IW-1:0] reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          play_valid,
    input  logic          play_ready,
    output logic [DW-1:0] play_data,
    input  logic          cap_valid,
    output logic          cap_ready,
    input  logic [DW-1:0] cap_data,
    output logic          irq_play,
    output logic          irq_cap
);
    localparam int WORD_BYTES = DW / 8;

    logic [NUM_CH-1:0] wr_ctrl, wr_addr, wr_left, ch_en, ch_irq, ch_step;
    logic [DW-1:0]     ch_addr [NUM_CH];
    logic [DW-1:0]     ch_rem  [NUM_CH];

    arb_state_e    arb_state;
    logic          play_want, cap_want, launch_play, launch_cap;
    logic          cap_full;
    logic [DW-1:0] cap_buf, req_addr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int BASE = BANK_FIRST + g * BANK_STRIDE;

        assign wr_ctrl[g] = reg_we && (reg_idx == IW'(BASE + FLD_CTRL));
        assign wr_addr[g] = reg_we && (reg_idx == IW'(BASE + FLD_ADDR));
        assign wr_left[g] = reg_we && (reg_idx == IW'(BASE + FLD_LEFT));

        audio_dma_chan #(.DW(DW), .WORD_BYTES(WORD_BYTES)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl[g]),
            .wr_addr (wr_addr[g]),
            .wr_left (wr_left[g]),
            .wdata   (reg_wdata),
            .step    (ch_step[g]),
            .en      (ch_en[g]),
            .addr    (ch_addr[g]),
            .left    (ch_rem[g]),
            .irq     (ch_irq[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_idx == IW'(BANK_FIRST + c * BANK_STRIDE + FLD_CTRL))
                reg_rdata = {{(DW-1){1'b0}}, ch_en[c]};
            if (reg_idx == IW'(BANK_FIRST + c * BANK_STRIDE + FLD_ADDR))
                reg_rdata = ch_addr[c];
            if (reg_idx == IW'(BANK_FIRST + c * BANK_STRIDE + FLD_LEFT))
                reg_rdata = ch_rem[c];
        end
    end

    // playback wants a word when its output slot is empty or draining this cycle
    assign play_want = ch_en[CH_PLAY] && (ch_rem[CH_PLAY] != '0) &&
                       (!play_valid || play_ready);
    assign cap_want  = ch_en[CH_CAP] && (ch_rem[CH_CAP] != '0) && cap_full;
    assign cap_ready = ch_en[CH_CAP] && (ch_rem[CH_CAP] != '0) && !cap_full;

    audio_dma_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .play_want   (play_want),
        .cap_want    (cap_want),
        .mem_ack     (mem_ack),
        .state       (arb_state),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .launch_play (launch_play),
        .launch_cap  (launch_cap),
        .play_step   (ch_step[CH_PLAY]),
        .cap_step    (ch_step[CH_CAP])
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr   <= '0;
            play_valid <= 1'b0;
            play_data  <= '0;
            cap_full   <= 1'b0;
            cap_buf    <= '0;
        end else begin
            if (launch_play)     req_addr <= ch_addr[CH_PLAY];
            else if (launch_cap) req_addr <= ch_addr[CH_CAP];

            if (ch_step[CH_PLAY]) begin
                play_valid <= 1'b1;
                play_data  <= mem_rdata;
            end else if (play_ready) begin
                play_valid <= 1'b0;
            end

            if (cap_valid && cap_ready) begin
                cap_full <= 1'b1;
                cap_buf  <= cap_data;
            end else if (ch_step[CH_CAP]) begin
                cap_full <= 1'b0;
            end
        end
    end

    assign mem_addr  = req_addr;
    assign mem_wdata = cap_buf;
    assign irq_play  = ch_irq[CH_PLAY];
    assign irq_cap   = ch_irq[CH_CAP];

endmodule

// File: rtl/audio_dma_chk.sv
module audio_dma_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          irq_play,
    input logic          irq_cap,
    input logic [DW-1:0] play_rem,
    input logic [DW-1:0] cap_rem,
    input logic          play_en,
    input logic          cap_en,
    input logic          cap_valid,
    input logic          cap_ready
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                                   (!mem_we || $stable(mem_wdata))));

    assert_play_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_play |=> !irq_play);

    assert_cap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cap |=> !irq_cap);

    assert_play_irq_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_play |-> (play_rem == '0));

    assert_cap_irq_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cap |-> (cap_rem == '0));

    assert_play_irq_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_play |-> $past(mem_req && mem_ack && !mem_we));

    assert_cap_irq_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cap |-> $past(mem_req && mem_ack && mem_we));

    assert_fetch_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we) |-> $past(play_en));

    assert_store_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> $past(cap_en));

    assert_cap_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_ready) |=> !cap_ready);
endmodule

bind audio_dma audio_dma_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq_play  (irq_play),
    .irq_cap   (irq_cap),
    .play_rem  (ch_rem[0]),
    .cap_rem   (ch_rem[1]),
    .play_en   (ch_en[0]),
    .cap_en    (ch_en[1]),
    .cap_valid (cap_valid),
    .cap_ready (cap_ready)
);

// File: tb/audio_dma_bench.sv
module audio_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        play_valid, play_ready = 1'b1;
    logic [31:0] play_data;
    logic        cap_valid = 1'b0, cap_ready;
    logic [31:0] cap_data = '0;
    logic        irq_play, irq_cap;

    int n_checks = 0, n_fail = 0;
    bit auto_ack = 1'b1, manual_go = 1'b0;
    int irq_play_cnt = 0, irq_cap_cnt = 0, req_cycles = 0;
    int frame_cnt = 0, wr_cnt = 0;
    logic [31:0] frames  [16];
    logic [31:0] wr_addr [16];
    logic [31:0] wr_data [16];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1357_0000;
    endfunction

    assign mem_rdata = pat(mem_addr);

    audio_dma u_audio_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .play_valid(play_valid),
        .play_ready(play_ready), .play_data(play_data), .cap_valid(cap_valid),
        .cap_ready(cap_ready), .cap_data(cap_data), .irq_play(irq_play),
        .irq_cap(irq_cap)
    );

    // memory model and monitors, all at the falling edge
    always @(negedge clk) begin
        if (play_valid && play_ready) begin
            if (frame_cnt < 16) frames[frame_cnt] = play_data;
            frame_cnt++;
        end
        if (irq_play) irq_play_cnt++;
        if (irq_cap)  irq_cap_cnt++;
        if (mem_req)  req_cycles++;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req && (auto_ack || manual_go)) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                if (wr_cnt < 16) begin
                    wr_addr[wr_cnt] = mem_addr;
                    wr_data[wr_cnt] = mem_wdata;
                end
                wr_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input logic [31:0] exp, input string req);
        reg_idx = 4'(idx);
        #1;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic clear_counts();
        irq_play_cnt = 0; irq_cap_cnt = 0; req_cycles = 0;
        frame_cnt = 0; wr_cnt = 0;
    endtask

    task automatic ack_once();
        @(posedge clk); #1 manual_go = 1'b1;
        @(negedge clk); #1 manual_go = 1'b0;
    endtask

    task automatic push(input logic [31:0] d, input int tries, output bit taken);
        taken = 1'b0;
        @(negedge clk);
        cap_valid = 1'b1; cap_data = d;
        for (int i = 0; i < tries; i++) begin
            #1;
            if (cap_ready) begin
                taken = 1'b1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        cap_valid = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        for (int i = 0; i < 16; i++) rd_chk(i, 32'h0, "R1 register after reset");
        check(!irq_play && !irq_cap, "R1 irqs", {irq_play, irq_cap}, 0);
        check(!mem_req && !play_valid && !cap_ready, "R1 idle outputs",
              {mem_req, play_valid, cap_ready}, 0);
    endtask

    task automatic t_regmap();
        wr(9, 32'h1234_5678);
        rd_chk(9, 32'h1234_5678, "R2 capture address readback");
        wr(5, 32'h0000_0ABC);
        rd_chk(5, 32'h0000_0ABC, "R2 playback address readback");
        wr(4, 32'hFFFF_FFFE);
        rd_chk(4, 32'h0, "R2 control keeps bit 0 only");
        wr(7, 32'hDEAD_BEEF);
        rd_chk(7, 32'h0, "R2 reserved index");
        wr(9, 0); wr(5, 0);
    endtask

    task automatic t_disabled();
        bit taken;
        clear_counts();
        wr(5, 32'h300); wr(6, 8); wr(9, 32'h380); wr(10, 8);
        push(32'h1111_2222, 10, taken);
        check(!taken, "R3 cap_ready low when disabled", taken, 0);
        repeat (10) @(negedge clk);
        check(req_cycles == 0, "R3 no request when disabled", req_cycles, 0);
        rd_chk(6, 8, "R3 playback count untouched");
        rd_chk(10, 8, "R3 capture count untouched");
        wr(6, 0); wr(10, 0);
    endtask

    task automatic t_zero_count();
        bit taken;
        clear_counts();
        wr(4, 1); wr(8, 1);
        push(32'h3333_4444, 10, taken);
        repeat (10) @(negedge clk);
        check(!taken, "R8 no capture accept at zero count", taken, 0);
        check(req_cycles == 0, "R8 no request at zero count", req_cycles, 0);
        check(irq_play_cnt + irq_cap_cnt == 0, "R8 no interrupt at zero count",
              irq_play_cnt + irq_cap_cnt, 0);
        wr(4, 0); wr(8, 0);
    endtask

    task automatic t_playback(input logic [31:0] base, input logic [31:0] cnt,
                              input int nfr);
        clear_counts();
        wr(5, base); wr(6, cnt); wr(4, 1);
        repeat (60) @(negedge clk);
        check(frame_cnt == nfr, "R4 frame count", frame_cnt, nfr);
        for (int i = 0; i < nfr && i < 16; i++)
            check(frames[i] === pat(base + 32'(4 * i)), "R4 frame data",
                  frames[i], pat(base + 32'(4 * i)));
        rd_chk(5, base + cnt, "R5 address advanced");
        rd_chk(6, 0, "R5 count drained");
        check(irq_play_cnt == 1, "R6 one playback pulse", irq_play_cnt, 1);
        wr(4, 0);
    endtask

    task automatic t_capture();
        bit taken;
        clear_counts();
        wr(9, 32'h200); wr(10, 8); wr(8, 1);
        push(32'hCAFE_0001, 20, taken);
        check(taken, "R7 first frame accepted", taken, 1);
        push(32'hCAFE_0002, 20, taken);
        check(taken, "R7 second frame accepted", taken, 1);
        repeat (10) @(negedge clk);
        check(wr_cnt == 2, "R7 write count", wr_cnt, 2);
        check(wr_addr[0] == 32'h200 && wr_data[0] == 32'hCAFE_0001,
              "R7 first write", wr_data[0], 32'hCAFE_0001);
        check(wr_addr[1] == 32'h204 && wr_data[1] == 32'hCAFE_0002,
              "R7 second write", wr_data[1], 32'hCAFE_0002);
        rd_chk(9, 32'h208, "R5 capture address advanced");
        check(irq_cap_cnt == 1, "R6 one capture pulse", irq_cap_cnt, 1);
        push(32'hCAFE_0003, 10, taken);
        check(!taken, "R7 no accept after drain", taken, 0);
        wr(8, 0);
    endtask

    task automatic t_priority();
        bit taken;
        clear_counts();
        auto_ack = 1'b0;
        wr(5, 32'h500); wr(6, 8); wr(4, 1);
        wr(9, 32'h600); wr(10, 4); wr(8, 1);
        push(32'hBEEF_0600, 20, taken);
        check(taken, "R9 capture frame buffered", taken, 1);
        check(mem_req && !mem_we && mem_addr == 32'h500, "R9 first fetch pending",
              mem_addr, 32'h500);
        ack_once();
        @(negedge clk);
        @(negedge clk);
        check(mem_req && !mem_we, "R9 playback wins tie", mem_we, 0);
        check(mem_addr == 32'h504, "R9 second fetch address", mem_addr, 32'h504);
        ack_once();
        @(negedge clk);
        @(negedge clk);
        check(mem_req && mem_we && mem_addr == 32'h600, "R9 store follows",
              mem_addr, 32'h600);
        check(mem_wdata == 32'hBEEF_0600, "R7 store data", mem_wdata, 32'hBEEF_0600);
        ack_once();
        repeat (4) @(negedge clk);
        check(irq_play_cnt == 1 && irq_cap_cnt == 1, "R6 both pulses",
              {irq_play_cnt[15:0], irq_cap_cnt[15:0]}, 32'h0001_0001);
        auto_ack = 1'b1;
        wr(4, 0); wr(8, 0);
    endtask

    task automatic t_collision();
        clear_counts();
        auto_ack = 1'b0;
        wr(5, 32'h700); wr(6, 4); wr(4, 1);
        wr(5, 32'h900);
        check(mem_req && mem_addr == 32'h700, "R11 request address held",
              mem_addr, 32'h700);
        @(posedge clk); #1 manual_go = 1'b1;
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 4'd6; reg_wdata = 32'd16;
        #1 manual_go = 1'b0;
        @(negedge clk);
        reg_we = 1'b0;
        rd_chk(6, 32'd16, "R10 written count wins");
        rd_chk(5, 32'h904, "R11 address advances from written value");
        wr(4, 0);
        auto_ack = 1'b1;
        repeat (10) @(negedge clk);
        check(irq_play_cnt == 0, "R10 no interrupt on collision", irq_play_cnt, 0);
        wr(6, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_disabled();
        t_zero_count();
        t_playback(32'h100, 12, 3);
        t_playback(32'h400, 6, 2);
        t_capture();
        t_priority();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule